// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block drives one pulse-width modulated pin. The time base is 10 bits wide. Its lower 2 bits come from a free-running sub-tick counter, and its upper 8 bits come from a timer that advances each time the sub-tick counter wraps. An 8-bit period value sets the cycle length, and a 10-bit duty value sets the high time. The duty value is given as an 8-bit coarse part and a 2-bit fine part.

The duty value presented by the register interface acts as the master copy. The block copies it into an internal slave register only at a period boundary, and the comparison always uses the slave copy. A write in the middle of a period therefore takes effect from the next period onward. The slave copy can be read back but cannot be written. When the block is disabled, it releases the pin, and the pin carries the port data bit instead. The pin's output-enable follows a separate direction input.

Top module: `pwm10_dbuf`

## Requirements
- R1: After synchronous reset, `slave_duty` reads 0. While `en` is low, `pin_o` equals `port_bit`.
- R2: The 2-bit sub-tick counter counts 0 to 3 and wraps to 0. On each wrap the 8-bit timer advances by one, so a period lasts (period+1)*4 clock cycles.
- R3: At a period boundary (sub-tick 3 with the timer equal to `period`), the next clock edge clears the timer and loads {duty_hi,duty_lo} into `slave_duty`. `slave_duty` changes at no other edge.
- R4: Within an armed period, `pin_o` is high while the 10-bit time base {timer,sub-tick} is below `slave_duty` and low from the match onward.
- R5: A latched duty of at least (period+1)*4 keeps `pin_o` high for the whole period.
- R6: A latched duty of 0 keeps `pin_o` low for the whole period.
- R7: After `en` rises, the counters start from 0 and `pin_o` stays low until the first period boundary loads the slave register.
- R8: A change of duty_hi/duty_lo in the middle of a period leaves the current pulse unchanged. The new value first shapes the following period.
- R9: While `en` is low, `pwm_own` is 0 and the counters are held at 0. When `en` is high, `pwm_own` is 1.
- R10: `pin_oe` equals `dir_out` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | PWM enable; low gives the pin back to the port latch |
| period | input | 8 | Timer terminal count |
| duty_hi | input | 8 | Master duty, upper 8 bits |
| duty_lo | input | 2 | Master duty, lower 2 bits |
| port_bit | input | 1 | Port data latch value used when released |
| dir_out | input | 1 | Pin direction, 1 = output |
| pin_o | output | 1 | Pin value |
| pin_oe | output | 1 | Pin output enable |
| pwm_own | output | 1 | High while the generator owns the pin |
| slave_duty | output | 10 | Read-back of the latched duty |

## Verification
On every cycle, the assertions check the sub-tick wrap and the timer advance, the slave load at a boundary together with its stability at all other edges, pin release while disabled, a low pin before the first load, and a low pin for a zero duty. The exact pulse shape can only be shown by the bench's scenarios, which predict the pin cycle by cycle. These scenarios cover the full-high case, the mid-period duty changes that must wait one period, and the first-period blanking, and they are run over many random periods and duties.

// File: rtl/pwm10_dbuf.sv
module pwm10_dbuf #(
  parameter int TW = 8,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [TW-1:0] period,
  input  logic [TW-1:0] duty_hi,
  input  logic [SW-1:0] duty_lo,
  input  logic          port_bit,
  input  logic          dir_out,
  output logic          pin_o,
  output logic          pin_oe,
  output logic          pwm_own,
  output logic [TW+SW-1:0] slave_duty
);
  localparam int BW = TW + SW;

  logic [TW-1:0] tmr;
  logic [SW-1:0] sub;
  logic          armed;

  wire sub_wrap = &sub;
  wire at_end   = sub_wrap && (tmr == period);

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr        <= '0;
      sub        <= '0;
      armed      <= 1'b0;
      slave_duty <= '0;
    end else if (!en) begin
      tmr   <= '0;
      sub   <= '0;
      armed <= 1'b0;
    end else begin
      sub <= sub + 1'b1;
      if (at_end) begin
        tmr        <= '0;
        armed      <= 1'b1;
        slave_duty <= {duty_hi, duty_lo};
      end else if (sub_wrap) begin
        tmr <= tmr + 1'b1;
      end
    end
  end

  wire [BW-1:0] tbase = {tmr, sub};
  wire          pwm   = armed && (tbase < slave_duty);

  assign pwm_own = en;
  assign pin_o   = en ? pwm : port_bit;
  assign pin_oe  = dir_out;
endmodule

// File: rtl/pwm10_dbuf_chk.sv
module pwm10_dbuf_chk #(
  parameter int TW = 8,
  parameter int SW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic [TW-1:0] period,
  input logic [TW-1:0] duty_hi,
  input logic [SW-1:0] duty_lo,
  input logic          port_bit,
  input logic          pin_o,
  input logic          pwm_own,
  input logic [TW+SW-1:0] slave_duty,
  input logic [TW-1:0] tmr,
  input logic [SW-1:0] sub,
  input logic          armed
);
  a_r2_sub_wrap: assert property (@(posedge clk) disable iff (rst)
    (en && &sub) |=> (sub == '0));

  a_r2_tmr_step: assert property (@(posedge clk) disable iff (rst)
    (en && &sub && tmr != period) |=> (!$past(en) || !en || tmr == $past(tmr) + 1'b1));

  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    (en && &sub && tmr == period) |=> (slave_duty == $past({duty_hi, duty_lo}) && tmr == '0));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !(en && &sub && tmr == period) |=> $stable(slave_duty));

  a_r6_zero_low: assert property (@(posedge clk) disable iff (rst)
    (en && slave_duty == '0) |-> !pin_o);

  a_r7_unarmed_low: assert property (@(posedge clk) disable iff (rst)
    (en && !armed) |-> !pin_o);

  a_r9_release: assert property (@(posedge clk) disable iff (rst)
    !en |-> (pin_o == port_bit && !pwm_own));
endmodule

bind pwm10_dbuf pwm10_dbuf_chk #(.TW(TW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .en(en), .period(period), .duty_hi(duty_hi),
  .duty_lo(duty_lo), .port_bit(port_bit), .pin_o(pin_o), .pwm_own(pwm_own),
  .slave_duty(slave_duty), .tmr(tmr), .sub(sub), .armed(armed)
);

// File: tb/test_pwm10_dbuf.sv
module test_pwm10_dbuf;
  logic       clk = 0;
  logic       rst, en, port_bit, dir_out;
  logic [7:0] period, duty_hi;
  logic [1:0] duty_lo;
  logic       pin_o, pin_oe, pwm_own;
  logic [9:0] slave_duty;

  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  pwm10_dbuf i_pwm10_dbuf (
    .clk(clk), .rst(rst), .en(en), .period(period), .duty_hi(duty_hi),
    .duty_lo(duty_lo), .port_bit(port_bit), .dir_out(dir_out),
    .pin_o(pin_o), .pin_oe(pin_oe), .pwm_own(pwm_own), .slave_duty(slave_duty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_pin(int i, int len, int lat);
    if (i < len) return 1'b0;
    return (i % len) < lat;
  endfunction

  function automatic string tag(int i, int len, int lat, bit mid);
    if (i < len) return "R7";
    if (lat == 0) return "R6";
    if (lat >= len) return "R5";
    return mid ? "R8" : "R4";
  endfunction

  task automatic set_duty(input int d);
    duty_hi = 8'(d >> 2);
    duty_lo = 2'(d);
  endtask

  task automatic run(input int p, input int d0, input int periods, input bit mid);
    int len = (p + 1) * 4;
    int master = d0;
    int lat = 0;
    @(negedge clk);
    period = 8'(p);
    set_duty(d0);
    en = 1'b1;
    for (int i = 0; i < periods * len; i++) begin
      if (i > 0) @(negedge clk);
      #1;
      chk(pin_o == exp_pin(i, len, lat), tag(i, len, lat, mid), pin_o, exp_pin(i, len, lat));
      if (i == 0) chk(pwm_own == 1'b1, "R9", pwm_own, 1);
      if (i >= len && i % len == 0)
        chk(slave_duty == 10'(lat), "R2 R3", slave_duty, lat);
      if (mid && ($urandom % 5 == 0)) begin
        master = $urandom % (len + 4);
        set_duty(master);
      end
      if (i % len == len - 1) lat = master & 10'h3ff;
    end
    @(negedge clk);
    en = 1'b0;
    for (int k = 0; k < 4; k++) begin
      port_bit = k[0];
      #1;
      chk(pin_o == port_bit, "R9", pin_o, port_bit);
      chk(pwm_own == 1'b0, "R9", pwm_own, 0);
      @(negedge clk);
    end
    chk(slave_duty == 10'(lat), "R3", slave_duty, lat);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst = 1; en = 0; port_bit = 1; dir_out = 0;
    period = 0; duty_hi = 0; duty_lo = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(slave_duty == 0, "R1", slave_duty, 0);
    chk(pin_o == 1'b1, "R1", pin_o, 1);
    rst = 0;
    @(negedge clk);
    #1;
    chk(slave_duty == 0, "R1", slave_duty, 0);
    for (int k = 0; k < 2; k++) begin
      dir_out = k[0];
      #1;
      chk(pin_oe == dir_out, "R10", pin_oe, dir_out);
    end
    run(0, 0, 3, 0);
    run(0, 2, 3, 0);
    run(0, 4, 3, 0);
    run(3, 7, 3, 0);
    run(3, 1023, 3, 0);
    run(255, 513, 3, 0);
    for (int s = 0; s < 10; s++) begin
      int p = $urandom % 16;
      run(p, $urandom % ((p + 1) * 4 + 4), 5, 1);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2ms;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule